// File: doc/BRIEF.md
# DMA Word Transfer Engine

The engine moves 16-bit words between a device-side word stream and host memory for a disk/tape adapter. Software-visible state (word count, base address and a 6-bit address extension) is handed to the engine with a start pulse. The engine then runs one of three modes, word by word, until the requested byte count is used up or an error stops it:

- **Read:** memory words are fetched and offered to the device.
- **Write:** device words are stored into memory.
- **Write-check:** each device word is compared against the memory word at the current address.

The memory side is a single-request port. It returns exactly one response per request, carrying a valid flag and a non-existent-memory flag. The device side uses two plain valid/ready word channels, one per direction.

When the run ends, the updated count, address and extension are written back on the block's outputs. A one-cycle done pulse tells the status logic that the run is over, and a transfer-error flag accompanies it if the run failed. The number of bytes actually moved or checked is reported on an output.

Top module: `dma_word_engine`

## Requirements
- R1: The byte address of the first memory access equals the extension input shifted left by 16, OR the 16-bit base input. The full address is 22 bits, and carries out of the low 16 bits propagate into the extension bits.
- R2: The transfer length in bytes is the smaller of two values: the requested byte count rounded down to even, and (65536 − word count) × 2. A word count of 0 therefore means 65536 words.
- R3: After each completed word the address advances by 2. When the increment-inhibit input is 1 at start, every word uses the start address.
- R4: Mode 2'b00 (read) fetches each memory word and presents it on the device output channel in address order. Mode 2'b11 behaves like 2'b00.
- R5: Mode 2'b01 (write) takes each device input word and stores it at the current memory address.
- R6: A memory response with the non-existent flag set ends the transfer, sets the NEM error output, and does not count that word.
- R7: Mode 2'b10 (check) loads each device word into the data buffer output and compares it with memory.
  - On a mismatch the engine sets the check error and stops, without counting that word or advancing the address.
  - It also sets either the odd flag (current address bit 0 = 1) or the even flag (bit 0 = 0).
- R8: At the end of a run:
  - the count output equals the start count plus the words moved, modulo 2^16;
  - the base output equals the low 16 address bits;
  - the extension output equals address bits 21:16;
  - the 2-bit extension mirror equals extension bits 1:0.
- R9: The byte-count output reports the bytes actually moved or checked (2 per completed word).
- R10: The end of every run gives exactly one single-cycle done pulse. The error flag is high with it exactly when a NEM or check error occurred. Busy is high from the accepted start until the done cycle. After reset the engine is idle with zeroed outputs.
- R11: A start pulse while busy is ignored: the running transfer is neither restarted nor altered.
- R12: A transfer whose length works out to zero raises done without any memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| mode | input | 2 | 00 read, 01 write, 10 check, 11 as read |
| incInhibit | input | 1 | Hold the address constant for the whole run |
| wcIn | input | 16 | Negative word count at start |
| baIn | input | 16 | Base byte address at start |
| extIn | input | 6 | Address extension at start |
| reqBytes | input | 18 | Requested byte count |
| devInValid | input | 1 | Device word available |
| devInData | input | 16 | Device word |
| devInReady | output | 1 | Engine takes the device word |
| devOutValid | output | 1 | Memory word offered to device |
| devOutData | output | 16 | Word offered to device |
| devOutReady | input | 1 | Device accepts the word |
| memReq | output | 1 | Single-cycle memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 22 | Byte address |
| memWdata | output | 16 | Write data |
| memRspValid | input | 1 | Memory response |
| memRspNxm | input | 1 | Address does not exist |
| memRdata | input | 16 | Read data |
| busy | output | 1 | Transfer running |
| done | output | 1 | One-cycle end pulse |
| tre | output | 1 | Error flag, qualified by done |
| nemErr | output | 1 | Non-existent memory seen |
| wceErr | output | 1 | Check mismatch seen |
| wcOdd | output | 1 | Mismatch at odd address |
| wcEven | output | 1 | Mismatch at even address |
| dbOut | output | 16 | Data buffer |
| bytesDone | output | 18 | Bytes moved or checked |
| wcOut | output | 16 | Written-back word count |
| baOut | output | 16 | Written-back base address |
| extOut | output | 6 | Written-back extension |
| uaeOut | output | 2 | Extension bits 1:0 mirror |

## Verification
The bench goes after the length limit from both sides:
- an odd request that must round down;
- a count of zero meaning 65536 words, where a design that treated it as empty would stop at once.

It runs a transfer across the 64 KiB boundary. A design without carry into the extension would write back a wrong extension and mirror.

Each error path is placed so that a slip shows in the outputs:
- A check mismatch after one good word, and another at an odd address. A design that counted the failing word, advanced past it or swapped the parity flags would report the wrong byte count, base or flag.
- A non-existent access at the first word and in the middle of a run, so a design that counted the failed word or kept going would be seen.

A second start during a running read must leave the memory request count and the written-back address unchanged.

// File: rtl/dwe_pkg.sv
package dwe_pkg;
  typedef enum logic [1:0] {
    MODE_READ  = 2'b00,
    MODE_WRITE = 2'b01,
    MODE_CHECK = 2'b10,
    MODE_ALT   = 2'b11
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic latchDev;
    logic latchMem;
    logic advance;
    logic setNem;
    logic setWce;
    logic commit;
  } strobe_t;
endpackage

// File: rtl/dwe_ctrl.sv
module dwe_ctrl
  import dwe_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  mode_e   modeLatched,
  input  logic    moreLeft,
  input  logic    mismatch,
  input  logic    memRspValid,
  input  logic    memRspNxm,
  input  logic    devInValid,
  input  logic    devOutReady,
  output strobe_t strb,
  output logic    busy,
  output logic    done,
  output logic    memReq,
  output logic    memWe,
  output logic    devInReady,
  output logic    devOutValid
);
  typedef enum logic [2:0] {
    S_IDLE, S_CHK, S_GET, S_ISSUE, S_WAIT, S_PUT, S_FIN
  } state_e;

  state_e state, nextState;
  logic   isReadMode;

  assign isReadMode = (modeLatched == MODE_READ) || (modeLatched == MODE_ALT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    strb        = '0;
    memReq      = 1'b0;
    memWe       = 1'b0;
    devInReady  = 1'b0;
    devOutValid = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          nextState = S_CHK;
        end
      end
      S_CHK: begin
        if (!moreLeft)       nextState = S_FIN;
        else if (isReadMode) nextState = S_ISSUE;
        else                 nextState = S_GET;
      end
      S_GET: begin
        devInReady = 1'b1;
        if (devInValid) begin
          strb.latchDev = 1'b1;
          nextState     = S_ISSUE;
        end
      end
      S_ISSUE: begin
        memReq    = 1'b1;
        memWe     = (modeLatched == MODE_WRITE);
        nextState = S_WAIT;
      end
      S_WAIT: begin
        if (memRspValid) begin
          if (memRspNxm) begin
            strb.setNem = 1'b1;
            nextState   = S_FIN;
          end else if (isReadMode) begin
            strb.latchMem = 1'b1;
            nextState     = S_PUT;
          end else if ((modeLatched == MODE_CHECK) && mismatch) begin
            strb.setWce = 1'b1;
            nextState   = S_FIN;
          end else begin
            strb.advance = 1'b1;
            nextState    = S_CHK;
          end
        end
      end
      S_PUT: begin
        devOutValid = 1'b1;
        if (devOutReady) begin
          strb.advance = 1'b1;
          nextState    = S_CHK;
        end
      end
      S_FIN: begin
        strb.commit = 1'b1;
        nextState   = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq); // R12
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && start) |=> busy); // R11
endmodule

// File: rtl/dwe_dpath.sv
module dwe_dpath
  import dwe_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int EXT_W  = 6,
  localparam int ADDR_W = WORD_W + EXT_W,
  localparam int CNT_W  = WORD_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  mode_e             modeIn,
  input  logic              incInhibit,
  input  logic [WORD_W-1:0] wcIn,
  input  logic [WORD_W-1:0] baIn,
  input  logic [EXT_W-1:0]  extIn,
  input  logic [CNT_W-1:0]  reqBytes,
  input  logic [WORD_W-1:0] memRdata,
  input  logic [WORD_W-1:0] devInData,
  output mode_e             modeLatched,
  output logic              moreLeft,
  output logic              mismatch,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] dataWord,
  output logic              nemErr,
  output logic              wceErr,
  output logic              wcOdd,
  output logic              wcEven,
  output logic [CNT_W-1:0]  bytesDone,
  output logic [WORD_W-1:0] wcOut,
  output logic [WORD_W-1:0] baOut,
  output logic [EXT_W-1:0]  extOut,
  output logic [1:0]        uaeOut
);
  logic [ADDR_W-1:0] addrReg;
  logic [CNT_W-1:0]  limitReg, byteCnt;
  logic [WORD_W-1:0] wcStart, dataReg;
  logic              inhReg;
  mode_e             modeReg;

  // length limit: min(even request, remaining words * 2)
  logic [WORD_W:0]   remWords;
  logic [CNT_W-1:0]  remBytes, reqEven, lenBytes;
  assign remWords = {1'b1, {WORD_W{1'b0}}} - {1'b0, wcIn};
  assign remBytes = {remWords, 1'b0};
  assign reqEven  = {reqBytes[CNT_W-1:1], 1'b0};
  assign lenBytes = (reqEven < remBytes) ? reqEven : remBytes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      limitReg <= '0;
      byteCnt  <= '0;
      wcStart  <= '0;
      dataReg  <= '0;
      inhReg   <= 1'b0;
      modeReg  <= MODE_READ;
      nemErr   <= 1'b0;
      wceErr   <= 1'b0;
      wcOdd    <= 1'b0;
      wcEven   <= 1'b0;
      wcOut    <= '0;
      baOut    <= '0;
      extOut   <= '0;
    end else begin
      if (strb.load) begin
        addrReg  <= {extIn, baIn};
        limitReg <= lenBytes;
        byteCnt  <= '0;
        wcStart  <= wcIn;
        inhReg   <= incInhibit;
        modeReg  <= modeIn;
        nemErr   <= 1'b0;
        wceErr   <= 1'b0;
        wcOdd    <= 1'b0;
        wcEven   <= 1'b0;
      end
      if (strb.latchDev) dataReg <= devInData;
      if (strb.latchMem) dataReg <= memRdata;
      if (strb.advance) begin
        byteCnt <= byteCnt + CNT_W'(2);
        if (!inhReg) addrReg <= addrReg + ADDR_W'(2);
      end
      if (strb.setNem) nemErr <= 1'b1;
      if (strb.setWce) begin
        wceErr <= 1'b1;
        if (addrReg[0]) wcOdd  <= 1'b1;
        else            wcEven <= 1'b1;
      end
      if (strb.commit) begin
        wcOut  <= wcStart + byteCnt[WORD_W:1];
        baOut  <= addrReg[WORD_W-1:0];
        extOut <= addrReg[ADDR_W-1:WORD_W];
      end
    end
  end

  assign modeLatched = modeReg;
  assign moreLeft    = (byteCnt < limitReg);
  assign mismatch    = (memRdata != dataReg);
  assign memAddr     = addrReg;
  assign dataWord    = dataReg;
  assign bytesDone   = byteCnt;
  assign uaeOut      = extOut[1:0];

  AST_BYTES_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= limitReg); // R2
  AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && inhReg) |=> $stable(addrReg)); // R3
  AST_PARITY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(wcOdd && wcEven)); // R7
  AST_ERR_STOPS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setNem || strb.setWce) |=> $stable(byteCnt)); // R6
endmodule

// File: rtl/dma_word_engine.sv
module dma_word_engine
  import dwe_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int EXT_W  = 6,
  localparam int ADDR_W = WORD_W + EXT_W,
  localparam int CNT_W  = WORD_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              incInhibit,
  input  logic [WORD_W-1:0] wcIn,
  input  logic [WORD_W-1:0] baIn,
  input  logic [EXT_W-1:0]  extIn,
  input  logic [CNT_W-1:0]  reqBytes,
  input  logic              devInValid,
  input  logic [WORD_W-1:0] devInData,
  output logic              devInReady,
  output logic              devOutValid,
  output logic [WORD_W-1:0] devOutData,
  input  logic              devOutReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic              memRspValid,
  input  logic              memRspNxm,
  input  logic [WORD_W-1:0] memRdata,
  output logic              busy,
  output logic              done,
  output logic              tre,
  output logic              nemErr,
  output logic              wceErr,
  output logic              wcOdd,
  output logic              wcEven,
  output logic [WORD_W-1:0] dbOut,
  output logic [CNT_W-1:0]  bytesDone,
  output logic [WORD_W-1:0] wcOut,
  output logic [WORD_W-1:0] baOut,
  output logic [EXT_W-1:0]  extOut,
  output logic [1:0]        uaeOut
);
  strobe_t           strb;
  mode_e             modeLatched;
  logic              moreLeft, mismatch;
  logic [WORD_W-1:0] dataWord;

  dwe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .modeLatched(modeLatched),
    .moreLeft(moreLeft), .mismatch(mismatch), .memRspValid(memRspValid),
    .memRspNxm(memRspNxm), .devInValid(devInValid), .devOutReady(devOutReady),
    .strb(strb), .busy(busy), .done(done), .memReq(memReq), .memWe(memWe),
    .devInReady(devInReady), .devOutValid(devOutValid)
  );

  dwe_dpath #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .modeIn(mode_e'(mode)),
    .incInhibit(incInhibit), .wcIn(wcIn), .baIn(baIn), .extIn(extIn),
    .reqBytes(reqBytes), .memRdata(memRdata), .devInData(devInData),
    .modeLatched(modeLatched), .moreLeft(moreLeft), .mismatch(mismatch),
    .memAddr(memAddr), .dataWord(dataWord), .nemErr(nemErr), .wceErr(wceErr),
    .wcOdd(wcOdd), .wcEven(wcEven), .bytesDone(bytesDone), .wcOut(wcOut),
    .baOut(baOut), .extOut(extOut), .uaeOut(uaeOut)
  );

  assign tre        = done && (nemErr || wceErr);
  assign dbOut      = dataWord;
  assign devOutData = dataWord;
  assign memWdata   = dataWord;

  AST_TRE_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rstN)
    tre |-> (nemErr || wceErr)); // R10
endmodule

// File: tb/dma_word_engine_bench.sv
module dma_word_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        incInhibit = 1'b0;
  logic [15:0] wcIn = '0, baIn = '0;
  logic [5:0]  extIn = '0;
  logic [17:0] reqBytes = '0;
  logic        devInValid, devInReady, devOutValid, devOutReady;
  logic [15:0] devInData, devOutData;
  logic        memReq, memWe, memRspValid, memRspNxm;
  logic [21:0] memAddr;
  logic [15:0] memWdata, memRdata;
  logic        busy, done, tre, nemErr, wceErr, wcOdd, wcEven;
  logic [15:0] dbOut, wcOut, baOut;
  logic [17:0] bytesDone;
  logic [5:0]  extOut;
  logic [1:0]  uaeOut;

  always #4 clk = ~clk; // 125 MHz

  dma_word_engine u_dma_word_engine (.*);

  int checks = 0, errors = 0, cyc = 0;

  // memory model: addr bit 21 set = non-existent, 1-cycle response
  logic [15:0] mem [256];
  logic        written [256];
  int          memReqCnt = 0;
  logic [21:0] lastAddr = '0;
  initial memRspValid = 1'b0;
  initial memRspNxm = 1'b0;
  initial memRdata = '0;
  initial for (int i = 0; i < 256; i++) written[i] = 1'b0;

  function automatic logic [15:0] pat(input logic [7:0] i);
    return {i, ~i} ^ 16'h5A00;
  endfunction

  always @(posedge clk) begin
    memRspValid <= memReq;
    memRspNxm   <= memReq && memAddr[21];
    memRdata    <= written[memAddr[8:1]] ? mem[memAddr[8:1]] : pat(memAddr[8:1]);
    if (memReq && memWe && !memAddr[21]) begin
      mem[memAddr[8:1]]     <= memWdata;
      written[memAddr[8:1]] <= 1'b1;
    end
    if (memReq) begin
      memReqCnt <= memReqCnt + 1;
      lastAddr  <= memAddr;
    end
  end

  // device source and sink
  logic [15:0] src [256];
  int srcN = 0, srcIdx = 0;
  logic [15:0] sink [256];
  int sinkN = 0;
  assign devInValid  = (srcIdx < srcN);
  assign devInData   = src[srcIdx[7:0]];
  assign devOutReady = 1'b1;
  always @(posedge clk) begin
    if (devInValid && devInReady) srcIdx <= srcIdx + 1;
    if (devOutValid && devOutReady) begin
      sink[sinkN[7:0]] <= devOutData;
      sinkN <= sinkN + 1;
    end
  end

  int doneCnt = 0;
  logic lastTre = 1'b0;
  always @(negedge clk) if (done) begin
    doneCnt <= doneCnt + 1;
    lastTre <= tre;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R10 watchdog actual=hang expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int reqBase, sinkBase, doneBase;
  logic [21:0] firstAddr;

  task automatic pushSrc(input logic [15:0] w);
    src[srcN[7:0]] = w;
    srcN = srcN + 1;
  endtask

  task automatic dropSrc();
    srcN = srcIdx;
  endtask

  task automatic run(input logic [1:0] m, input logic [5:0] e, input logic [15:0] b,
                     input logic [15:0] w, input logic [17:0] r, input logic inh);
    @(negedge clk);
    reqBase = memReqCnt; sinkBase = sinkN; doneBase = doneCnt;
    mode = m; extIn = e; baIn = b; wcIn = w; reqBytes = r; incInhibit = inh;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    firstAddr = memAddr;
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 reset busy", busy, 0);
    chk("R10 reset done", done, 0);
    chk("R10 reset wcOut", wcOut, 0);
    chk("R9 reset bytes", bytesDone, 0);
  endtask

  task automatic t_read();
    run(2'b00, 6'h00, 16'h0100, 16'hFFFC, 18'd100, 1'b0);
    chk("R1 first addr", firstAddr, 22'h000100);
    chk("R2 read bytes", bytesDone, 8);
    for (int k = 0; k < 4; k++)
      chk("R4 read word", sink[(sinkBase + k) % 256], pat(8'h80 + 8'(k)));
    chk("R8 read wc", wcOut, 16'h0000);
    chk("R8 read ba", baOut, 16'h0108);
    chk("R10 read done once", doneCnt - doneBase, 1);
    chk("R10 read no tre", lastTre, 0);
  endtask

  task automatic t_write();
    dropSrc();
    pushSrc(16'h1111); pushSrc(16'h2222); pushSrc(16'h3333); pushSrc(16'h4444);
    run(2'b01, 6'h00, 16'h0040, 16'hFFF0, 18'd7, 1'b0);
    chk("R2 odd request rounds down", bytesDone, 6);
    chk("R5 write w0", mem[8'h20], 16'h1111);
    chk("R5 write w1", mem[8'h21], 16'h2222);
    chk("R5 write w2", mem[8'h22], 16'h3333);
    chk("R5 no extra write", written[8'h23], 0);
    chk("R8 write wc", wcOut, 16'hFFF3);
    chk("R8 write ba", baOut, 16'h0046);
  endtask

  task automatic t_inhibit();
    dropSrc();
    pushSrc(16'hAAA1); pushSrc(16'hAAA2); pushSrc(16'hAAA3);
    run(2'b01, 6'h00, 16'h0080, 16'hFFFD, 18'd100, 1'b1);
    chk("R3 inhibit last word", mem[8'h40], 16'hAAA3);
    chk("R3 inhibit neighbour", written[8'h41], 0);
    chk("R3 inhibit ba", baOut, 16'h0080);
    chk("R9 inhibit bytes", bytesDone, 6);
  endtask

  task automatic t_carry();
    run(2'b11, 6'h01, 16'hFFFE, 16'hFFFE, 18'd100, 1'b0);
    chk("R1 carry first addr", firstAddr, 22'h01FFFE);
    chk("R4 carry w0", sink[sinkBase % 256], pat(8'hFF));
    chk("R4 carry w1", sink[(sinkBase + 1) % 256], pat(8'h00));
    chk("R8 carry ba", baOut, 16'h0002);
    chk("R8 carry ext", extOut, 6'h02);
    chk("R8 carry mirror", uaeOut, 2'b10);
    chk("R8 carry wc", wcOut, 16'h0000);
  endtask

  task automatic t_check_ok();
    dropSrc();
    pushSrc(pat(8'h80)); pushSrc(pat(8'h81)); pushSrc(pat(8'h82));
    run(2'b10, 6'h00, 16'h0100, 16'hFFFD, 18'd100, 1'b0);
    chk("R7 check ok bytes", bytesDone, 6);
    chk("R7 check ok no err", wceErr, 0);
    chk("R10 check ok tre", lastTre, 0);
  endtask

  task automatic t_check_even();
    dropSrc();
    pushSrc(pat(8'h80)); pushSrc(pat(8'h81) ^ 16'h0001); pushSrc(pat(8'h82));
    run(2'b10, 6'h00, 16'h0100, 16'hFFF0, 18'd20, 1'b0);
    chk("R7 even err", wceErr, 1);
    chk("R7 even flag", wcEven, 1);
    chk("R7 even not odd", wcOdd, 0);
    chk("R7 even bytes", bytesDone, 2);
    chk("R7 even ba", baOut, 16'h0102);
    chk("R8 even wc", wcOut, 16'hFFF1);
    chk("R7 even db", dbOut, pat(8'h81) ^ 16'h0001);
    chk("R10 even tre", lastTre, 1);
  endtask

  task automatic t_check_odd();
    dropSrc();
    pushSrc(pat(8'h80) ^ 16'h0100);
    run(2'b10, 6'h00, 16'h0101, 16'hFFF0, 18'd20, 1'b0);
    chk("R7 odd flag", wcOdd, 1);
    chk("R7 odd not even", wcEven, 0);
    chk("R7 odd bytes", bytesDone, 0);
    chk("R7 odd ba", baOut, 16'h0101);
  endtask

  task automatic t_nxm_first();
    dropSrc();
    pushSrc(16'h7777); pushSrc(16'h8888);
    run(2'b01, 6'h20, 16'h0000, 16'hFFF0, 18'd4, 1'b0);
    chk("R6 nxm flag", nemErr, 1);
    chk("R6 nxm bytes", bytesDone, 0);
    chk("R6 nxm one access", memReqCnt - reqBase, 1);
    chk("R6 nxm wc kept", wcOut, 16'hFFF0);
    chk("R10 nxm tre", lastTre, 1);
  endtask

  task automatic t_nxm_mid();
    run(2'b00, 6'h1F, 16'hFFFC, 16'hFFF0, 18'd6, 1'b0);
    chk("R6 mid bytes", bytesDone, 4);
    chk("R6 mid sink count", sinkN - sinkBase, 2);
    chk("R6 mid ext", extOut, 6'h20);
    chk("R6 mid ba", baOut, 16'h0000);
    chk("R6 mid nem", nemErr, 1);
  endtask

  task automatic t_lengths();
    run(2'b00, 6'h00, 16'h0100, 16'h0000, 18'd6, 1'b0);
    chk("R2 zero count is 65536 words", bytesDone, 6);
    chk("R8 zero count wc", wcOut, 16'h0003);
    run(2'b00, 6'h00, 16'h0100, 16'hFFF0, 18'd1, 1'b0);
    chk("R12 empty bytes", bytesDone, 0);
    chk("R12 empty no access", memReqCnt - reqBase, 0);
    chk("R12 empty done", doneCnt - doneBase, 1);
  endtask

  task automatic t_restart();
    @(negedge clk);
    reqBase = memReqCnt; doneBase = doneCnt; sinkBase = sinkN;
    mode = 2'b00; extIn = 6'h00; baIn = 16'h0100; wcIn = 16'hFFFC;
    reqBytes = 18'd100; incInhibit = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    mode = 2'b01; baIn = 16'h0200; wcIn = 16'hFFFF;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R11 still idle", busy, 0);
    chk("R11 accesses", memReqCnt - reqBase, 4);
    chk("R11 done once", doneCnt - doneBase, 1);
    chk("R11 ba from first", baOut, 16'h0108);
    chk("R11 sink words", sinkN - sinkBase, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_read();
    t_write();
    t_inhibit();
    t_carry();
    t_check_ok();
    t_check_even();
    t_check_odd();
    t_nxm_first();
    t_nxm_mid();
    t_lengths();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule